// File: doc/BRIEF.md
# Bimodal Branch Predictor with Return Stack

This block supplies the front end of a single-issue, in-order pipeline with a guess for each fetched control-flow instruction. Conditional branches are predicted from a direct-mapped table of 2-bit saturating counters. Returns are predicted from a circular stack of return addresses that resolved calls push. The fetch side presents a word-aligned PC and a class hint and reads back a taken flag and a target in the same cycle.

The resolve side reports the real outcome of the slot fetched two cycles earlier. A live resolve trains the counters and updates the stack. A live mispredict produces a registered redirect three cycles after that slot was fetched. The block kills the two younger slots already in flight and holds back fetch for the redirect cycle. A mispredict therefore costs three fetch slots, and a correct guess costs none.

Fetch uses a valid/ready handshake. A slot is fetched on a cycle where both `fetch_valid` and `fetch_ready` are high. `fetch_ready` drops only in the redirect cycle, and the source must hold its request over that cycle, where it is not taken. The prediction outputs are pure lookups and do not depend on the handshake. Resolve, redirect and liveness are plain control pins.

Top module: `bimodal_ras_predictor`

## Requirements
- R1: After reset every counter reads weakly not-taken (value 1) and the stack is empty. `fetch_ready` is 1, and `resolve_live` and `redirect_valid` are 0.
- R2: Class codes on `fetch_kind` and `res_kind` are 0 plain, 1 conditional, 2 call and 3 return. For class 1, `pred_taken` is bit 1 of the counter indexed by PC bits [10:2] (so 2 and 3 mean taken). For class 3, `pred_taken` is 1 exactly when the stack is not empty. For classes 0 and 2, `pred_taken` is 0.
- R3: A live resolve of class 1 moves the indexed counter up by one if taken and down by one if not, saturating at 3 and at 0.
- R4: A live resolve of class 2 pushes `res_pc`+4. A live resolve of class 3 pops the top entry. For class 3 with a non-empty stack, `pred_target` is the top entry. Otherwise `pred_target` is 0.
- R5: The stack holds 16 entries. A push onto a full stack overwrites the oldest entry, and the occupancy stays at 16.
- R6: A pop on an empty stack leaves the stack unchanged.
- R7: `resolve_live` is 1 exactly when a fetch handshake took place two cycles earlier and that slot has not been killed by a redirect.
- R8: When `res_valid`, `resolve_live` and `res_mispredict` are all 1 in a cycle, `redirect_valid` is 1 in the next cycle, three cycles after that slot's fetch. In that cycle `redirect_pc` equals the `res_target` given, and `fetch_ready` is 0.
- R9: The two slots fetched in the two cycles after a mispredicted slot never become live. Resolves driven for them change neither counters nor stack and cause no redirect.
- R10: A live resolve with `res_mispredict` at 0 causes no redirect, and `fetch_ready` stays 1.
- R11: A resolve with `res_valid` at 1 while `resolve_live` is 0 has no effect on counters, stack or redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch slot request |
| fetch_ready | output | 1 | Fetch slot accepted (low in redirect cycle) |
| fetch_pc | input | 32 | Word-aligned fetch address |
| fetch_kind | input | 2 | Class hint of fetched instruction |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | 32 | Predicted return target |
| res_valid | input | 1 | Resolve info for the slot at resolve stage |
| res_pc | input | 32 | PC of resolving slot |
| res_kind | input | 2 | Class of resolving slot |
| res_taken | input | 1 | Actual direction of a conditional |
| res_mispredict | input | 1 | Prediction was wrong |
| res_target | input | 32 | Correct next PC on mispredict |
| resolve_live | output | 1 | Slot at resolve stage is on the correct path |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Redirect address |

## Verification
The assertions assume that fetch addresses are word aligned whenever `fetch_valid` is high. They also assume that a resolve reports the slot fetched exactly two cycles before, so a mispredict is only expected while that slot is live. The stimulus draws PCs with the low two bits cleared and derives each resolve's PC and class from the bench's own record of handshakes two cycles back. It also deliberately raises `res_valid` for killed or empty slots, which must be ignored.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_COND  = 2'd1,
    K_CALL  = 2'd2,
    K_RET   = 2'd3
  } kind_e;
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int ENTRIES = 512,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_pc,
  output logic          rd_taken,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_pc,
  input  logic          wr_taken
);
  localparam int IW = $clog2(ENTRIES);

  logic [1:0]    ctr [ENTRIES];
  logic [IW-1:0] rd_idx, wr_idx;

  assign rd_idx   = rd_pc[IW+1:2];
  assign wr_idx   = wr_pc[IW+1:2];
  assign rd_taken = ctr[rd_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= 2'd1;
    end else if (wr_en) begin
      if (wr_taken && ctr[wr_idx] != 2'd3)
        ctr[wr_idx] <= ctr[wr_idx] + 2'd1;
      else if (!wr_taken && ctr[wr_idx] != 2'd0)
        ctr[wr_idx] <= ctr[wr_idx] - 2'd1;
    end
  end

  // R3: a taken update from a non-saturated counter raises it by one
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_pc[IW+1:2] == rd_pc[IW+1:2] && ctr[wr_idx] == 2'd1)
      |=> (ctr[$past(wr_idx)] == 2'd2));
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top,
  output logic          nonempty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr, ptr_inc, ptr_dec;
  logic [CW-1:0] cnt;

  assign ptr_inc  = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign ptr_dec  = (ptr == '0) ? PW'(DEPTH - 1) : ptr - 1'b1;
  assign nonempty = (cnt != '0);
  assign top      = mem[ptr_dec];

  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (push) begin
      ptr <= ptr_inc;
      if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop && nonempty) begin
      ptr <= ptr_dec;
      cnt <= cnt - 1'b1;
    end
  end

  assert_occupancy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_empty_pop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !nonempty) |=> ($stable(ptr) && !nonempty));
endmodule

// File: rtl/bp_recover.sv
module bp_recover #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic          res_valid,
  input  logic          res_mispredict,
  input  logic [AW-1:0] res_target,
  output logic          resolve_live,
  output logic          upd_en,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  logic v1, v2, miss;

  assign fetch_ready  = !redirect_valid;
  assign resolve_live = v2;
  assign upd_en       = res_valid && v2;
  assign miss         = upd_en && res_mispredict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc <= '0;
    end else begin
      redirect_valid <= miss;
      if (miss) begin
        redirect_pc <= res_target;
        v1 <= 1'b0;
        v2 <= 1'b0;
      end else begin
        v1 <= fetch_valid && fetch_ready;
        v2 <= v1;
      end
    end
  end

  assert_redirect_follows_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && resolve_live && res_mispredict) |=> redirect_valid);

  assert_redirect_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && resolve_live && res_mispredict) |=> (redirect_pc == $past(res_target)));

  assert_wrong_path_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!resolve_live && !redirect_valid));

  assert_no_spurious_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && resolve_live && res_mispredict) |=> !redirect_valid);
endmodule

// File: rtl/bimodal_ras_predictor.sv
module bimodal_ras_predictor #(
  parameter int ENTRIES   = 512,
  parameter int RAS_DEPTH = 16,
  parameter int AW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [AW-1:0] fetch_pc,
  input  logic [1:0]    fetch_kind,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target,
  input  logic          res_valid,
  input  logic [AW-1:0] res_pc,
  input  logic [1:0]    res_kind,
  input  logic          res_taken,
  input  logic          res_mispredict,
  input  logic [AW-1:0] res_target,
  output logic          resolve_live,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  import bp_pkg::*;

  kind_e         f_kind, r_kind;
  logic          upd_en, ctr_taken, stk_nonempty;
  logic [AW-1:0] stk_top;

  assign f_kind = kind_e'(fetch_kind);
  assign r_kind = kind_e'(res_kind);

  bp_recover #(.AW(AW)) u_recover (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .res_valid(res_valid), .res_mispredict(res_mispredict),
    .res_target(res_target), .resolve_live(resolve_live),
    .upd_en(upd_en), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  bp_ctr_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_taken(ctr_taken),
    .wr_en(upd_en && r_kind == K_COND), .wr_pc(res_pc),
    .wr_taken(res_taken)
  );

  bp_ret_stack #(.DEPTH(RAS_DEPTH), .AW(AW)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(upd_en && r_kind == K_CALL), .push_addr(res_pc + AW'(4)),
    .pop(upd_en && r_kind == K_RET), .top(stk_top),
    .nonempty(stk_nonempty)
  );

  always_comb begin
    pred_taken  = 1'b0;
    pred_target = '0;
    unique case (f_kind)
      K_COND: pred_taken = ctr_taken;
      K_RET: begin
        pred_taken = stk_nonempty;
        if (stk_nonempty) pred_target = stk_top;
      end
      default: ;
    endcase
  end

  assert_fetch_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_pc[1:0] == 2'b00));

  assert_return_guess_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f_kind == K_RET && !stk_nonempty) |-> (!pred_taken && pred_target == '0));
endmodule

// File: tb/test_bimodal_ras_predictor.sv
module test_bimodal_ras_predictor;
  localparam int NENT = 512;
  localparam int NSTK = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_pc = '0;
  logic [1:0]  fetch_kind = '0;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [1:0]  res_kind = '0;
  logic        res_taken = 1'b0;
  logic        res_mispredict = 1'b0;
  logic [31:0] res_target = '0;
  logic        resolve_live;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bimodal_ras_predictor i_bimodal_ras_predictor (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .fetch_kind(fetch_kind),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .res_valid(res_valid), .res_pc(res_pc), .res_kind(res_kind),
    .res_taken(res_taken), .res_mispredict(res_mispredict),
    .res_target(res_target), .resolve_live(resolve_live),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  // reference state
  logic [1:0]  m_ctr [NENT];
  logic [31:0] m_stk [NSTK];
  int          m_ptr, m_cnt;
  bit          m_v1, m_v2, m_redir;
  logic [31:0] m_rpc;
  // bench record of handshakes (not of liveness)
  bit          h1v, h2v;
  logic [31:0] h1pc, h2pc;
  logic [1:0]  h1k, h2k;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int top_idx();
    return (m_ptr == 0) ? NSTK - 1 : m_ptr - 1;
  endfunction

  function automatic logic exp_taken(input logic [31:0] pc, input logic [1:0] k);
    if (k == 2'd1) return m_ctr[pc[10:2]][1];
    if (k == 2'd3) return m_cnt > 0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_target(input logic [1:0] k);
    if (k == 2'd3 && m_cnt > 0) return m_stk[top_idx()];
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) m_ctr[i] = 2'd1;
    m_ptr = 0; m_cnt = 0;
    m_v1 = 0; m_v2 = 0; m_redir = 0; m_rpc = '0;
    h1v = 0; h2v = 0; h1pc = '0; h2pc = '0; h1k = '0; h2k = '0;
  endtask

  task automatic step(input bit fv, input logic [31:0] pc, input logic [1:0] kd,
                      input bit tk, input bit mp, input bit rv_extra);
    bit hs, live, miss;
    @(negedge clk);
    fetch_valid    = fv;
    fetch_pc       = pc;
    fetch_kind     = kd;
    res_valid      = h2v | rv_extra;
    res_pc         = h2pc;
    res_kind       = h2k;
    res_taken      = tk;
    res_mispredict = mp;
    res_target     = $urandom & 32'hFFFF_FFFC;
    #1;
    chk("R2/R3", {31'd0, pred_taken}, {31'd0, exp_taken(pc, kd)});
    chk("R4/R5/R6", pred_target, exp_target(kd));
    chk("R8/R10", {31'd0, fetch_ready}, {31'd0, !m_redir});
    chk("R7/R9/R11", {31'd0, resolve_live}, {31'd0, m_v2});
    chk("R8", {31'd0, redirect_valid}, {31'd0, m_redir});
    if (m_redir) chk("R8", redirect_pc, m_rpc);
    // advance the reference
    hs   = fv && !m_redir;
    live = res_valid && m_v2;
    miss = live && mp;
    if (live) begin
      if (res_kind == 2'd1) begin
        if (tk && m_ctr[res_pc[10:2]] != 2'd3) m_ctr[res_pc[10:2]]++;
        else if (!tk && m_ctr[res_pc[10:2]] != 2'd0) m_ctr[res_pc[10:2]]--;
      end else if (res_kind == 2'd2) begin
        m_stk[m_ptr] = res_pc + 32'd4;
        m_ptr = (m_ptr + 1) % NSTK;
        if (m_cnt < NSTK) m_cnt++;
      end else if (res_kind == 2'd3 && m_cnt > 0) begin
        m_ptr = top_idx();
        m_cnt--;
      end
    end
    if (miss) begin
      m_rpc = res_target;
      m_v1 = 0; m_v2 = 0;
    end else begin
      m_v2 = m_v1; m_v1 = hs;
    end
    m_redir = miss;
    h2v = h1v; h2pc = h1pc; h2k = h1k;
    h1v = hs;  h1pc = pc;   h1k = kd;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    fetch_pc = 32'h0000_0040; fetch_kind = 2'd1;
    #1;
    chk("R1", {31'd0, pred_taken}, 32'd0);
    chk("R1", {31'd0, fetch_ready}, 32'd1);
    chk("R1", {31'd0, resolve_live}, 32'd0);
    chk("R1", {31'd0, redirect_valid}, 32'd0);
    fetch_kind = 2'd3;
    #1;
    chk("R1", {31'd0, pred_taken}, 32'd0);
    chk("R1", pred_target, 32'd0);

    // R4/R5: overfill the stack with calls, then drain past empty (R6)
    for (int i = 0; i < 20; i++) step(1, 32'h1000 + i * 16, 2'd2, 0, 0, 0);
    step(0, 0, 2'd0, 0, 0, 0);
    step(0, 0, 2'd0, 0, 0, 0);
    for (int i = 0; i < 22; i++) step(1, 32'h2000, 2'd3, 0, 0, 0);
    step(0, 0, 2'd3, 0, 0, 0);
    step(0, 0, 2'd3, 0, 0, 0);

    // R3: saturate one counter up, then walk it down to zero
    for (int i = 0; i < 6; i++) step(1, 32'h0000_0400, 2'd1, 1, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 32'h0000_0400, 2'd1, 0, 0, 0);
    step(0, 32'h0000_0400, 2'd1, 0, 0, 0);
    step(0, 32'h0000_0400, 2'd1, 0, 0, 0);

    // R8/R9: back-to-back fetch with a mispredict on the first resolve
    step(1, 32'h0000_0800, 2'd1, 1, 0, 0);
    step(1, 32'h0000_0804, 2'd1, 1, 0, 0);
    step(1, 32'h0000_0808, 2'd1, 1, 1, 0);
    step(1, 32'h0000_080C, 2'd1, 1, 1, 0);
    step(1, 32'h0000_0810, 2'd1, 1, 1, 0);
    step(1, 32'h0000_0814, 2'd1, 1, 0, 0);
    // R11: resolve asserted with no live slot
    step(0, 0, 2'd0, 1, 1, 1);
    step(0, 0, 2'd0, 1, 1, 1);
    step(0, 0, 2'd0, 1, 1, 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] pc;
      pc = (i % 4 == 0) ? {22'd0, 8'($urandom_range(0, 15)), 2'b00}
                        : ($urandom & 32'hFFFF_FFFC);
      step($urandom_range(0, 9) < 8, pc, 2'($urandom),
           1'($urandom), $urandom_range(0, 99) < 15,
           $urandom_range(0, 9) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule